// File: doc/BRIEF.md
# Two-Port Static Memory with Collision Arbitration

This block is a 1024-word by 8-bit memory that two independent agents, called left and right, can read and write at the same time. Each side has an active-low chip enable, a read/write select (high reads, low writes), an active-low output enable, a 10-bit address, an 8-bit write bus and an 8-bit read bus. A drive-enable output goes with each read bus. It stands in for the tri-state control of a pad: when it is low, the read bus is held at zero and should be treated as high impedance. The model uses one clock. All inputs are sampled on the rising edge, writes take effect on that edge, and every output is registered, so it shows the result of the inputs sampled at the previous edge.

When both sides are enabled on the same address, an arbiter picks a loser and drives that side's active-low busy flag. A write from the losing side is dropped. A read from the losing side still returns the stored word, and a suspect bit marks that data as possibly invalid. A side arrives in a cycle in which it becomes enabled, or in which its address changes while it stays enabled. The side that arrives later loses. If both arrive in the same cycle, the right side loses. A mode input selects slave operation. In that mode the arbiter's decision does not act on writes, both busy outputs are held high, and the two busy inputs gate writes instead.

Top module: `twin_port_ram`

## Requirements
- R1: While a side's chip enable is high, that side writes nothing, and after the next edge its drive-enable is 0 and its read bus is 0.
- R2: With chip enable low and read/write low, the write bus is stored at the addressed word on the rising edge, unless that side's write is blocked (R7, R8).
- R3: With chip enable low, read/write high and output enable low, after the edge the read bus carries the addressed word and drive-enable is 1. A word written by the other side on the same edge is returned with its old value. With output enable high, drive-enable is 0 and the read bus is 0.
- R4: A busy output goes low only when, at the previous edge, both chip enables were low and the two addresses were equal. In every other case both busy outputs are high.
- R5: On a match the later-arriving side is flagged busy. A side arrives when it becomes enabled, or when its address changes while it is enabled. On a tie the right side is flagged. While both sides hold their state, the flag stays on the same side.
- R6: The two busy outputs are never low together.
- R7: In master mode (slave_mode = 0), a write from the side that loses arbitration at an edge is discarded, and the busy inputs have no effect.
- R8: In slave mode (slave_mode = 1), both busy outputs stay high. A low busy input discards that side's write at that edge, and same-address matches block nothing.
- R9: A read from a side that is blocked still returns the stored word, with its suspect bit at 1 after the edge. The suspect bit is 0 for reads that are not blocked.
- R10: A busy flag returns high after the first edge at which the match or either enable has gone away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 1 = busy flags come from the busy inputs |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_rw | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 10 | Left word address |
| l_din | input | 8 | Left write data |
| l_busy_n_i | input | 1 | Left busy input (slave mode) |
| l_dout | output | 8 | Left read data |
| l_dout_en | output | 1 | Left read bus drive-enable |
| l_dout_suspect | output | 1 | Left read data may be invalid |
| l_busy_n_o | output | 1 | Left busy flag, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_rw | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 10 | Right word address |
| r_din | input | 8 | Right write data |
| r_busy_n_i | input | 1 | Right busy input (slave mode) |
| r_dout | output | 8 | Right read data |
| r_dout_en | output | 1 | Right read bus drive-enable |
| r_dout_suspect | output | 1 | Right read data may be invalid |
| r_busy_n_o | output | 1 | Right busy flag, active low |

## Verification
The bench writes every address and reads every address back through the other side. This exposes an address decode or a write-enable that is swapped between the sides. It then builds collisions in three ways: both sides arriving together, one side arriving after the other, and one side moving its address onto the other's. A design that judged arrival only by enable edges would flag the wrong side in the address-move case, and a design that broke ties the wrong way would let the right side's data win. Read-during-write on the same edge and a held collision check that the array reads first and that the flag neither flips nor lingers. Slave mode with low busy inputs, and master mode with the same inputs low, catch a design that looks at the wrong busy source.

// File: rtl/twin_ram_pkg.sv
package twin_ram_pkg;
  localparam int unsigned TR_ADDR_W = 10;
  localparam int unsigned TR_DATA_W = 8;

  typedef enum logic [1:0] {
    LOSE_NONE  = 2'd0,
    LOSE_LEFT  = 2'd1,
    LOSE_RIGHT = 2'd2
  } loser_e;
endpackage

// File: rtl/twin_ram_store.sv
module twin_ram_store #(
  parameter int unsigned AW = twin_ram_pkg::TR_ADDR_W,
  parameter int unsigned DW = twin_ram_pkg::TR_DATA_W
) (
  input  logic          clk,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Array reads are combinational; the port blocks register them, so a
  // same-edge write is seen as old data (read-first).
  assign l_rdata = mem[l_addr];
  assign r_rdata = mem[r_addr];

  // Left is written last so it takes the word if both hit one address
  // (only reachable in slave mode with both busy inputs released).
  always_ff @(posedge clk) begin
    if (r_we) mem[r_addr] <= r_wdata;
    if (l_we) mem[l_addr] <= l_wdata;
  end
endmodule

// File: rtl/twin_ram_arbiter.sv
module twin_ram_arbiter #(
  parameter int unsigned AW = twin_ram_pkg::TR_ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_req,
  input  logic [AW-1:0] l_addr,
  input  logic          r_req,
  input  logic [AW-1:0] r_addr,
  output logic          l_lose,
  output logic          r_lose,
  output logic          l_busy_q,
  output logic          r_busy_q
);
  import twin_ram_pkg::*;

  logic          l_req_q, r_req_q;
  logic [AW-1:0] l_addr_q, r_addr_q;
  loser_e        loser_q, loser_d;
  logic          match, l_new, r_new;

  assign match = l_req && r_req && (l_addr == r_addr);
  assign l_new = l_req && (!l_req_q || (l_addr != l_addr_q));
  assign r_new = r_req && (!r_req_q || (r_addr != r_addr_q));

  always_comb begin
    loser_d = LOSE_NONE;
    if (match) begin
      if (l_new && !r_new)      loser_d = LOSE_LEFT;
      else if (r_new)           loser_d = LOSE_RIGHT;
      else if (loser_q != LOSE_NONE) loser_d = loser_q;
      else                      loser_d = LOSE_RIGHT;
    end
  end

  assign l_lose = (loser_d == LOSE_LEFT);
  assign r_lose = (loser_d == LOSE_RIGHT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_req_q  <= 1'b0;
      r_req_q  <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
      loser_q  <= LOSE_NONE;
    end else begin
      l_req_q  <= l_req;
      r_req_q  <= r_req;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
      loser_q  <= loser_d;
    end
  end

  assign l_busy_q = (loser_q == LOSE_LEFT);
  assign r_busy_q = (loser_q == LOSE_RIGHT);

  p_idle_clears_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !match |=> (loser_q == LOSE_NONE));
  p_match_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (loser_q != LOSE_NONE));
  p_late_right_loses_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match && r_new && !l_new) |=> (loser_q == LOSE_RIGHT));
  p_late_left_loses_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match && l_new && !r_new) |=> (loser_q == LOSE_LEFT));
  p_flag_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !l_new && !r_new && loser_q == LOSE_LEFT) |=> (loser_q == LOSE_LEFT));
endmodule

// File: rtl/twin_ram_port.sv
module twin_ram_port #(
  parameter int unsigned AW = twin_ram_pkg::TR_ADDR_W,
  parameter int unsigned DW = twin_ram_pkg::TR_DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          rw,
  input  logic          oe_n,
  input  logic          blk,
  input  logic [DW-1:0] rdata_i,
  output logic          mem_we,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          dout_suspect
);
  logic          rd_fire;
  logic [DW-1:0] rd_q, rd_d;
  logic          en_q, en_d;
  logic          sus_q, sus_d;

  assign rd_fire = !ce_n && rw;
  assign mem_we  = !ce_n && !rw && !blk;

  always_comb begin
    rd_d  = rd_q;
    if (rd_fire) rd_d = rdata_i;
    en_d  = rd_fire && !oe_n;
    sus_d = rd_fire && !oe_n && blk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      en_q  <= 1'b0;
      sus_q <= 1'b0;
    end else begin
      rd_q  <= rd_d;
      en_q  <= en_d;
      sus_q <= sus_d;
    end
  end

  assign dout         = en_q ? rd_q : '0;
  assign dout_en      = en_q;
  assign dout_suspect = sus_q;

  p_quiet_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0));
  p_blocked_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    blk |-> !mem_we);
  p_disabled_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !mem_we);
endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram #(
  parameter int unsigned AW = twin_ram_pkg::TR_ADDR_W,
  parameter int unsigned DW = twin_ram_pkg::TR_DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slave_mode,
  input  logic          l_ce_n,
  input  logic          l_rw,
  input  logic          l_oe_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_din,
  input  logic          l_busy_n_i,
  output logic [DW-1:0] l_dout,
  output logic          l_dout_en,
  output logic          l_dout_suspect,
  output logic          l_busy_n_o,
  input  logic          r_ce_n,
  input  logic          r_rw,
  input  logic          r_oe_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_din,
  input  logic          r_busy_n_i,
  output logic [DW-1:0] r_dout,
  output logic          r_dout_en,
  output logic          r_dout_suspect,
  output logic          r_busy_n_o
);
  logic          l_lose, r_lose, l_busy_q, r_busy_q;
  logic          l_blk, r_blk, l_we, r_we;
  logic [DW-1:0] l_rdata, r_rdata;

  twin_ram_arbiter #(.AW(AW)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .l_req(!l_ce_n), .l_addr(l_addr),
    .r_req(!r_ce_n), .r_addr(r_addr),
    .l_lose(l_lose), .r_lose(r_lose),
    .l_busy_q(l_busy_q), .r_busy_q(r_busy_q)
  );

  // Write gating source: own arbiter in master mode, pins in slave mode.
  assign l_blk = slave_mode ? !l_busy_n_i : l_lose;
  assign r_blk = slave_mode ? !r_busy_n_i : r_lose;

  assign l_busy_n_o = slave_mode ? 1'b1 : !l_busy_q;
  assign r_busy_n_o = slave_mode ? 1'b1 : !r_busy_q;

  twin_ram_port #(.AW(AW), .DW(DW)) u_lport (
    .clk(clk), .rst_n(rst_n), .ce_n(l_ce_n), .rw(l_rw), .oe_n(l_oe_n),
    .blk(l_blk), .rdata_i(l_rdata), .mem_we(l_we), .dout(l_dout),
    .dout_en(l_dout_en), .dout_suspect(l_dout_suspect)
  );

  twin_ram_port #(.AW(AW), .DW(DW)) u_rport (
    .clk(clk), .rst_n(rst_n), .ce_n(r_ce_n), .rw(r_rw), .oe_n(r_oe_n),
    .blk(r_blk), .rdata_i(r_rdata), .mem_we(r_we), .dout(r_dout),
    .dout_en(r_dout_en), .dout_suspect(r_dout_suspect)
  );

  twin_ram_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk),
    .l_we(l_we), .l_addr(l_addr), .l_wdata(l_din), .l_rdata(l_rdata),
    .r_we(r_we), .r_addr(r_addr), .r_wdata(r_din), .r_rdata(r_rdata)
  );

  p_busy_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n_o && !r_busy_n_o));
  p_master_blocks_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_mode |-> !(l_blk && r_blk));
  p_slave_flags_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |=> (l_busy_n_o && r_busy_n_o) || !$past(slave_mode) || !slave_mode);
endmodule

// File: tb/twin_port_ram_bench.sv
module twin_port_ram_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, slave_mode;
  logic l_ce_n, l_rw, l_oe_n, l_busy_n_i, r_ce_n, r_rw, r_oe_n, r_busy_n_i;
  logic [9:0] l_addr, r_addr;
  logic [7:0] l_din, r_din, l_dout, r_dout;
  logic l_dout_en, l_dout_suspect, l_busy_n_o, r_dout_en, r_dout_suspect, r_busy_n_o;

  logic [7:0] model [1024];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twin_port_ram u_twin_port_ram (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
    .l_ce_n(l_ce_n), .l_rw(l_rw), .l_oe_n(l_oe_n), .l_addr(l_addr), .l_din(l_din),
    .l_busy_n_i(l_busy_n_i), .l_dout(l_dout), .l_dout_en(l_dout_en),
    .l_dout_suspect(l_dout_suspect), .l_busy_n_o(l_busy_n_o),
    .r_ce_n(r_ce_n), .r_rw(r_rw), .r_oe_n(r_oe_n), .r_addr(r_addr), .r_din(r_din),
    .r_busy_n_i(r_busy_n_i), .r_dout(r_dout), .r_dout_en(r_dout_en),
    .r_dout_suspect(r_dout_suspect), .r_busy_n_o(r_busy_n_o)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 13 + (a >> 3) + 5) & 255);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    l_ce_n = 1; l_rw = 1; l_oe_n = 0; r_ce_n = 1; r_rw = 1; r_oe_n = 0;
  endtask

  task automatic lset(logic ce_n, logic rw, int a, logic [7:0] d);
    l_ce_n = ce_n; l_rw = rw; l_addr = 10'(a); l_din = d;
  endtask

  task automatic rset(logic ce_n, logic rw, int a, logic [7:0] d);
    r_ce_n = ce_n; r_rw = rw; r_addr = 10'(a); r_din = d;
  endtask

  task automatic rread_chk(string req, int a);
    idle(); tick();
    rset(0, 1, a, 8'h00); tick();
    check(req, r_dout, model[a]);
    idle(); tick();
  endtask

  task automatic busy_chk(string req, logic lb, logic rb);
    check(req, {l_busy_n_o, r_busy_n_o}, {lb, rb});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; slave_mode = 0; l_busy_n_i = 1; r_busy_n_i = 1;
    l_addr = 0; r_addr = 0; l_din = 0; r_din = 0;
    idle();
    repeat (3) @(negedge clk);
    // R1 / R4: reset state
    check("R1 reset l_dout_en", l_dout_en, 0);
    check("R1 reset r_dout", r_dout, 0);
    busy_chk("R4 reset busy", 1, 1);
    rst_n = 1;
    tick();

    // R2: fill every word from the left
    for (int a = 0; a < 1024; a++) begin
      lset(0, 0, a, pat(a)); model[a] = pat(a); tick();
    end
    idle(); tick();
    // R3: read every word from the right
    for (int a = 0; a < 1024; a++) begin
      rset(0, 1, a, 8'h00); tick();
      check("R3 right read data", r_dout, model[a]);
      check("R3 right drive-enable", r_dout_en, 1);
      if (a % 128 == 0) check("R9 unblocked suspect", r_dout_suspect, 0);
    end
    idle(); tick();
    // R2 from right, R3 read back on left (strided)
    for (int k = 0; k < 64; k++) begin
      int a = (k * 37 + 11) % 1024;
      rset(0, 0, a, 8'(~pat(a))); model[a] = 8'(~pat(a)); tick();
      idle(); tick();
      lset(0, 1, a, 8'h00); tick();
      check("R2 right write, left read", l_dout, model[a]);
      idle(); tick();
    end

    // R3: output enable high
    rset(0, 1, 5, 8'h00); r_oe_n = 1; tick();
    check("R3 oe high drive-enable", r_dout_en, 0);
    check("R3 oe high bus", r_dout, 0);
    idle(); tick();

    // R1: disabled side with write select does not store
    lset(1, 0, 7, 8'h5A); tick();
    check("R1 disabled drive-enable", l_dout_en, 0);
    rread_chk("R1 disabled no write", 7);

    // R4: different addresses, no busy, both writes land
    lset(0, 0, 3, 8'hA1); rset(0, 0, 4, 8'hB2); model[3] = 8'hA1; model[4] = 8'hB2; tick();
    busy_chk("R4 no match", 1, 1);
    idle(); tick();
    rread_chk("R4 left write", 3);
    rread_chk("R4 right write", 4);
    // R4: same address but one side disabled
    lset(1, 0, 9, 8'h00); rset(0, 1, 9, 8'h00); tick();
    busy_chk("R4 one side disabled", 1, 1);
    idle(); tick();

    // R5 / R9: left moves its address onto the right's
    lset(0, 1, 3, 8'h00); rset(0, 1, 4, 8'h00); tick();
    busy_chk("R5 before move", 1, 1);
    l_addr = 10'd4; tick();
    busy_chk("R5 address move loses", 0, 1);
    check("R9 blocked read data", l_dout, model[4]);
    check("R9 blocked suspect", l_dout_suspect, 1);
    check("R9 winner suspect", r_dout_suspect, 0);
    for (int i = 0; i < 3; i++) begin
      tick();
      busy_chk("R5 flag holds", 0, 1);
    end
    // R10: release
    l_ce_n = 1; tick();
    busy_chk("R10 release", 1, 1);
    idle(); tick();

    // R5 / R7: right arrives later, its write dropped
    lset(0, 0, 20, 8'hC3); model[20] = 8'hC3; tick();
    l_din = 8'hC4; rset(0, 0, 20, 8'hD5); model[20] = 8'hC4; tick();
    busy_chk("R5 late right", 1, 0);
    idle(); tick();
    busy_chk("R10 release after idle", 1, 1);
    rread_chk("R7 late right write dropped", 20);

    // R5 tie: right flagged, left data stored
    lset(0, 0, 30, 8'h11); rset(0, 0, 30, 8'h22); model[30] = 8'h11; tick();
    busy_chk("R5 tie right flagged", 1, 0);
    rread_chk("R7 tie left kept", 30);

    // R5 / R7: left arrives later
    rset(0, 0, 40, 8'h33); model[40] = 8'h33; tick();
    lset(0, 0, 40, 8'h44); tick();
    busy_chk("R5 late left", 0, 1);
    rread_chk("R7 late left write dropped", 40);

    // R3 read-first during other side write (tie: right read flagged)
    lset(0, 0, 100, 8'hE7); rset(0, 1, 100, 8'h00); tick();
    check("R3 read-first old data", r_dout, model[100]);
    check("R9 tie read suspect", r_dout_suspect, 1);
    model[100] = 8'hE7;
    rread_chk("R2 write after read-first", 100);

    // R7: busy inputs ignored in master mode
    l_busy_n_i = 0; r_busy_n_i = 0;
    lset(0, 0, 50, 8'h66); model[50] = 8'h66; tick();
    busy_chk("R7 master ignores inputs", 1, 1);
    l_busy_n_i = 1; r_busy_n_i = 1;
    rread_chk("R7 master write with input low", 50);

    // R8: slave mode
    slave_mode = 1;
    lset(0, 1, 60, 8'h00); rset(0, 1, 60, 8'h00); tick();
    busy_chk("R8 slave flags high", 1, 1);
    check("R8 slave no suspect", r_dout_suspect, 0);
    idle(); tick();
    l_busy_n_i = 0;
    lset(0, 0, 61, 8'h99); tick();
    l_busy_n_i = 1;
    rread_chk("R8 slave left blocked", 61);
    r_busy_n_i = 0;
    rset(0, 0, 62, 8'h5C); tick();
    idle(); tick();
    rset(0, 1, 62, 8'h00); tick();
    check("R8 slave right blocked", r_dout, model[62]);
    check("R9 slave blocked read suspect", r_dout_suspect, 1);
    r_busy_n_i = 1;
    rset(0, 0, 62, 8'h5C); model[62] = 8'h5C; tick();
    rread_chk("R8 slave right write released", 62);
    lset(0, 0, 70, 8'h12); rset(0, 1, 70, 8'h00); model[70] = 8'h12; tick();
    busy_chk("R8 slave match no flag", 1, 1);
    rread_chk("R8 slave match write kept", 70);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule